// File: doc/BRIEF.md
# Variable-Block Carry Select Adder

A purely combinational binary adder. It splits the operand width into blocks, and the blocks grow wider toward the most significant end. The lowest block is an ordinary ripple adder fed by the external carry input.

Every higher block holds two adders that work in parallel. One assumes the incoming block carry is 0 and the other assumes it is 1. When the real carry arrives from the block below, it steers a multiplexer. That multiplexer picks the matching sum bits and the matching block carry-out, which then selects in the next block.

The block widths come from a parameter, so the same code covers different splits. Under a delay model where a k-bit block costs k units and each selection stage costs one unit, each block's candidate results are ready about when its select carry arrives. The default is an 8-bit adder split into widths 2, 2 and 4, counted from the least significant end.

Top module: `csel_adder`

## Requirements
- R1: For every input, {cout, sum} equals the arithmetic value a + b + cin, taken as WIDTH+1 bits.
- R2: Every block above the lowest computes two candidates in parallel, with block carry-in forced to 0 and to 1. The carry-in-1 candidate is exactly one greater than the carry-in-0 candidate.
- R3: The carry-out of an upper block is the carry-in-1 candidate's carry when the incoming carry is 1, and the carry-in-0 candidate's carry otherwise. A block whose bits all propagate (a XOR b all ones) passes its incoming carry straight through.
- R4: The lowest block adds cin directly. For fixed a and b, setting cin to 1 raises {cout, sum} by exactly one.
- R5: cout is 1 exactly when a + b + cin is greater than 2^WIDTH - 1.
- R6: Block boundaries follow the width parameter; the default boundaries sit after bit 1 and after bit 3. A carry born in one block reaches the bits above those boundaries correctly.
- R7: a and b all ones with cin = 1 gives sum all ones and cout = 1. a all ones, b zero and cin = 1 gives sum zero and cout = 1, a carry that travels through every block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into the lowest block |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the top block |

## Verification
Every pair of 8-bit operands is applied with cin at 0. This finds any wrong sum bit or carry under any carry pattern across the block boundaries. A random set with cin at 1 separates a correct lowest block from one that drops the external carry. Directed vectors place a carry exactly at each boundary, make whole blocks propagate, and run a carry through all blocks. These vectors show whether each multiplexer picks the right candidate and passes the incoming carry on.

// File: rtl/csel_adder.sv
module csel_adder #(
  parameter int WIDTH = 8,
  parameter int NBLK  = 3,
  parameter logic [NBLK*8-1:0] BLK_W = {8'd4, 8'd2, 8'd2}
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  function automatic int blk_w(int i);
    return int'(BLK_W[i*8 +: 8]);
  endfunction

  function automatic int blk_lo(int i);
    int lo = 0;
    for (int k = 0; k < i; k++) lo += blk_w(k);
    return lo;
  endfunction

  logic [NBLK:0] c;
  assign c[0] = cin;
  assign cout = c[NBLK];

  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    localparam int W  = blk_w(i);
    localparam int LO = blk_lo(i);
    if (i == 0) begin : g_ripple
      assign {c[1], sum[LO +: W]} = {1'b0, a[LO +: W]} + {1'b0, b[LO +: W]} + (W+1)'(c[0]);
    end else begin : g_select
      logic [W:0] r0, r1;
      assign r0 = {1'b0, a[LO +: W]} + {1'b0, b[LO +: W]};
      assign r1 = {1'b0, a[LO +: W]} + {1'b0, b[LO +: W]} + (W+1)'(1);
      assign sum[LO +: W] = c[i] ? r1[W-1:0] : r0[W-1:0];
      assign c[i+1]       = c[i] ? r1[W]     : r0[W];

      always_comb begin
        assert_pair_step_R2: assert (r1 == r0 + (W+1)'(1));
        assert_carry_order_R3: assert (!r0[W] || r1[W]);
        if (&(a[LO +: W] ^ b[LO +: W]))
          assert_prop_pass_R3: assert (c[i+1] == c[i]);
      end
    end
  end

  always_comb begin
    assert_total_R1: assert ({cout, sum} == {1'b0, a} + {1'b0, b} + (WIDTH+1)'(cin));
  end

endmodule

// File: tb/test_csel_adder.sv
module test_csel_adder;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  typedef struct {
    logic [W:0] exp;
    string      req;
  } item_t;

  logic clk = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic cin = 1'b0;
  logic [W-1:0] sum;
  logic cout;
  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  csel_adder i_csel_adder (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic drive(input logic [W-1:0] ta, input logic [W-1:0] tb, input logic tc,
                       input string req);
    item_t it;
    @(negedge clk);
    a = ta; b = tb; cin = tc;
    it.exp = {1'b0, ta} + {1'b0, tb} + (W+1)'(tc);
    it.req = req;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_run++;
      if ({cout, sum} !== it.exp) begin
        n_fail++;
        $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h",
                 it.req, a, b, cin, {cout, sum}, it.exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    drive(8'h00, 8'h00, 1'b0, "R1 zero inputs");
    drive(8'h03, 8'h01, 1'b0, "R6 carry across boundary after bit 1");
    drive(8'h0F, 8'h01, 1'b0, "R6 carry across boundary after bit 3");
    drive(8'h0C, 8'h04, 1'b0, "R6 carry born in middle block");
    drive(8'h05, 8'h0A, 1'b1, "R3 middle block propagates incoming carry");
    drive(8'h3C, 8'hC3, 1'b0, "R3 upper blocks propagate with no carry");
    drive(8'hFF, 8'h00, 1'b1, "R7 carry through every block");
    drive(8'hFF, 8'hFF, 1'b1, "R7 all ones with cin");
    drive(8'h80, 8'h80, 1'b0, "R5 cout from top bits");
    drive(8'h7F, 8'h80, 1'b0, "R5 no cout at maximum");
    drive(8'h55, 8'h2A, 1'b1, "R4 cin adds one");
    drive(8'h55, 8'h2A, 1'b0, "R4 cin zero");
    drive(8'hF0, 8'h0F, 1'b1, "R2 upper blocks take carry-in-1 candidate");
    for (int i = 0; i < 2000; i++)
      drive(W'($urandom), W'($urandom), 1'b1, "R4 random with cin set");
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++)
        drive(W'(x), W'(y), 1'b0, "R1 exhaustive");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule